// File: doc/BRIEF.md
# OTP Word Programming Sequencer

This controller burns a range of 16-bit words into a one-time-programmable array whose cells start at all ones and can only be pulled to zero. Once started, it walks the address window from its first to its last address in ascending order. For each word it fetches the target value from an external source and reads the cell once. It then applies fixed-width, active-low program pulses, with a verify read after every pulse, until the word reads back equal to the target or the pulse budget runs out.

When every word in the window has been programmed, the sequencer makes one more pass over the whole window and only reads. The first mismatch stops the run. A target with a one in a bit that already holds a zero can never be reached, so that word is rejected before any pulse is issued. Every failure leaves a cause code, the failing address and the number of pulses spent on it. All timing (pulse width, setup before the pulse, hold after it, read latency) is counted in clock cycles set by parameters.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, and whenever the sequencer is not busy, prog_n is 1, rd_req is 0, and done, busy and err_code are 0 until the first run completes.
- R2: A run visits the addresses from first_addr to last_addr (first_addr <= last_addr, both latched at start) in ascending order. For each word it drives cell_wdata with the src_data value that the source returned for that cell_addr. A word that passes verify holds exactly that value in the array.
- R3: Each program pulse drives prog_n low for exactly PULSE_CYC cycles. cell_addr and cell_wdata stay unchanged for at least SETUP_CYC cycles before the pulse and throughout it. HOLD_CYC cycles with prog_n high and rd_req low follow each pulse before the verify read begins.
- R4: Every read (initial, after each pulse, and in the final pass) holds rd_req high for exactly RD_LAT cycles. rd_data is sampled in the last of those cycles. rd_req is never high while prog_n is low.
- R5: Before the first pulse on a word, the cell is read once. If it already equals the target, the word gets no pulse.
- R6: If the target has a 1 where the initial read shows a 0, the run stops with no pulse on that word. It then reports err_code 1, fail_addr set to that address, and fail_cnt 0.
- R7: Pulses repeat until the verify read equals the target. The number of pulses a word receives equals the number its cell needs, up to MAX_PULSES (default 25).
- R8: If the word still mismatches after MAX_PULSES pulses, the run stops and reports err_code 2, fail_addr set to that address, and fail_cnt equal to MAX_PULSES.
- R9: After the last word, a final pass rereads every word of the window in ascending order with final_pass high and no pulses. The first mismatch reports err_code 3, fail_addr set to that word, and fail_cnt 0.
- R10: At the end of every run, done goes to 1, and err_code is nonzero exactly when the run failed. done and the results hold until the next start. A start while busy is ignored, together with the first_addr and last_addr that come with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| first_addr | input | AW | First address of the window |
| last_addr | input | AW | Last address of the window |
| src_data | input | DW | Target data for the current cell_addr |
| prog_n | output | 1 | Active-low program pulse |
| cell_addr | output | AW | Address presented to the array |
| cell_wdata | output | DW | Data presented to the array |
| rd_req | output | 1 | Verify read request |
| rd_data | input | DW | Read data returned by the array |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has ended |
| final_pass | output | 1 | The whole-window verify pass is in progress |
| err_code | output | 2 | 0 ok, 1 unreachable target, 2 pulse budget exhausted, 3 final pass mismatch |
| fail_addr | output | AW | Address of the failing word |
| fail_cnt | output | CW | Pulses spent on the failing word |

## Verification
The bench models each cell as needing a random number of pulses. It includes a word that never programs, which a sequencer without a retry bound would pulse forever, and a word that needs exactly the full budget, which an off-by-one limit would wrongly fail. A pre-programmed word catches a design that pulses without the initial read, and a word with a zero under a target one catches a design that pulses it anyway and then reports a retry failure instead. A bit disturbed in an earlier word after it passed is caught only by the final pass. A mid-run start with a different window would show up as a wrong address order if the design accepted it.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_PRE_RD,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_VRD,
        S_ADV,
        S_FLOAD,
        S_FRD
    } seq_state_e;

    typedef enum logic [1:0] {
        ERK_NONE   = 2'd0,
        ERK_UNPROG = 2'd1,
        ERK_STUCK  = 2'd2,
        ERK_FINAL  = 2'd3
    } err_kind_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/otp_wait_timer.sv
// Down-counter shared by all timed phases: loaded with N-1, expired at zero.
module otp_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_word_check.sv
// Compares read-back against the target word.
module otp_word_check #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] target,
    input  logic [DW-1:0] readback,
    output logic          match,
    output logic          unprog
);
    always_comb begin
        match  = (target == readback);
        // a bit that must be 1 but already reads 0 cannot be restored
        unprog = |(target & ~readback);
    end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int PULSE_CYC  = 25000,
    parameter int SETUP_CYC  = 2,
    parameter int HOLD_CYC   = 2,
    parameter int RD_LAT     = 2,
    parameter int MAX_PULSES = 25,
    parameter int CW         = $clog2(MAX_PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    input  logic [DW-1:0] src_data,
    output logic          prog_n,
    output logic [AW-1:0] cell_addr,
    output logic [DW-1:0] cell_wdata,
    output logic          rd_req,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          final_pass,
    output logic [1:0]    err_code,
    output logic [AW-1:0] fail_addr,
    output logic [CW-1:0] fail_cnt
);
    localparam int TMAX = max2(max2(PULSE_CYC, SETUP_CYC), max2(HOLD_CYC, RD_LAT));
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_PULSE = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] T_RD    = TW'(RD_LAT - 1);
    localparam logic [CW-1:0] PMAX    = CW'(MAX_PULSES);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] first;
        logic [AW-1:0] last;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [CW-1:0] pcnt;
        logic          done;
        err_kind_e     err;
        logic [AW-1:0] faddr;
        logic [CW-1:0] fcnt;
        logic          fin;
    } seq_t;

    seq_t r_d, r_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          w_match;
    logic          w_unprog;

    otp_wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    otp_word_check #(.DW(DW)) u_check (
        .target   (r_q.wdata),
        .readback (rd_data),
        .match    (w_match),
        .unprog   (w_unprog)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st    = S_LOAD;
                    r_d.first = first_addr;
                    r_d.last  = last_addr;
                    r_d.addr  = first_addr;
                    r_d.pcnt  = '0;
                    r_d.done  = 1'b0;
                    r_d.err   = ERK_NONE;
                    r_d.faddr = '0;
                    r_d.fcnt  = '0;
                    r_d.fin   = 1'b0;
                end
            end
            S_LOAD: begin
                r_d.wdata = src_data;
                r_d.pcnt  = '0;
                tmr_load  = 1'b1;
                tmr_val   = T_RD;
                r_d.st    = S_PRE_RD;
            end
            S_PRE_RD: begin
                if (tmr_zero) begin
                    if (w_unprog) begin
                        r_d.st    = S_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = ERK_UNPROG;
                        r_d.faddr = r_q.addr;
                        r_d.fcnt  = '0;
                    end else if (w_match) begin
                        r_d.st = S_ADV;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = T_SETUP;
                        r_d.st   = S_SETUP;
                    end
                end
            end
            S_SETUP: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                    r_d.st   = S_PULSE;
                end
            end
            S_PULSE: begin
                if (tmr_zero) begin
                    r_d.pcnt = r_q.pcnt + CW'(1);
                    tmr_load = 1'b1;
                    tmr_val  = T_HOLD;
                    r_d.st   = S_HOLD;
                end
            end
            S_HOLD: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = T_RD;
                    r_d.st   = S_VRD;
                end
            end
            S_VRD: begin
                if (tmr_zero) begin
                    if (w_match) begin
                        r_d.st = S_ADV;
                    end else if (r_q.pcnt >= PMAX) begin
                        r_d.st    = S_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = ERK_STUCK;
                        r_d.faddr = r_q.addr;
                        r_d.fcnt  = r_q.pcnt;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = T_SETUP;
                        r_d.st   = S_SETUP;
                    end
                end
            end
            S_ADV: begin
                if (r_q.addr == r_q.last) begin
                    r_d.addr = r_q.first;
                    r_d.fin  = 1'b1;
                    r_d.st   = S_FLOAD;
                end else begin
                    r_d.addr = r_q.addr + AW'(1);
                    r_d.st   = S_LOAD;
                end
            end
            S_FLOAD: begin
                r_d.wdata = src_data;
                tmr_load  = 1'b1;
                tmr_val   = T_RD;
                r_d.st    = S_FRD;
            end
            S_FRD: begin
                if (tmr_zero) begin
                    if (!w_match) begin
                        r_d.st    = S_IDLE;
                        r_d.done  = 1'b1;
                        r_d.err   = ERK_FINAL;
                        r_d.faddr = r_q.addr;
                        r_d.fcnt  = '0;
                        r_d.fin   = 1'b0;
                    end else if (r_q.addr == r_q.last) begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                        r_d.fin  = 1'b0;
                    end else begin
                        r_d.addr = r_q.addr + AW'(1);
                        r_d.st   = S_FLOAD;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_IDLE;
            r_q.err   <= ERK_NONE;
            r_q.wdata <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_n     = (r_q.st != S_PULSE);
    assign rd_req     = (r_q.st == S_PRE_RD) || (r_q.st == S_VRD) || (r_q.st == S_FRD);
    assign cell_addr  = r_q.addr;
    assign cell_wdata = r_q.wdata;
    assign busy       = (r_q.st != S_IDLE);
    assign done       = r_q.done;
    assign final_pass = r_q.fin;
    assign err_code   = r_q.err;
    assign fail_addr  = r_q.faddr;
    assign fail_cnt   = r_q.fcnt;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int PULSE_CYC  = 25000,
    parameter int MAX_PULSES = 25,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_n,
    input logic          rd_req,
    input logic          busy,
    input logic          done,
    input logic          final_pass,
    input logic [AW-1:0] cell_addr,
    input logic [DW-1:0] cell_wdata,
    input logic [1:0]    err_code,
    input logic [CW-1:0] fail_cnt
);
    int low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_q <= 0;
        else if (!prog_n) low_q <= low_q + 1;
        else              low_q <= 0;
    end

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n) |-> low_q == PULSE_CYC);

    a_r3_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n && $past(!prog_n)) |-> ($stable(cell_addr) && $stable(cell_wdata)));

    a_r4_no_read_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && !prog_n));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (prog_n && !rd_req));

    a_r9_no_pulse_final: assert property (@(posedge clk) disable iff (!rst_n)
        final_pass |-> prog_n);

    a_r10_err_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> done);

    a_r8_budget_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == 2'd2) |-> fail_cnt == CW'(MAX_PULSES));
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .rd_req(rd_req), .busy(busy),
    .done(done), .final_pass(final_pass), .cell_addr(cell_addr),
    .cell_wdata(cell_wdata), .err_code(err_code), .fail_cnt(fail_cnt)
);

// File: tb/otp_prog_seq_bench.sv
module otp_prog_seq_bench;
    localparam int AW = 6, DW = 16;
    localparam int PW = 12, SU = 2, HO = 3, RL = 2, MP = 25;
    localparam int CW = $clog2(MP + 1);

    logic clk = 0, rst_n = 0, start = 0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic [DW-1:0] src_data, rd_data, cell_wdata;
    logic [AW-1:0] cell_addr, fail_addr;
    logic prog_n, rd_req, busy, done, final_pass;
    logic [1:0] err_code;
    logic [CW-1:0] fail_cnt;

    always #2 clk = ~clk;

    otp_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PW), .SETUP_CYC(SU), .HOLD_CYC(HO),
                   .RD_LAT(RL), .MAX_PULSES(MP)) u_otp_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
        .last_addr(last_addr), .src_data(src_data), .prog_n(prog_n),
        .cell_addr(cell_addr), .cell_wdata(cell_wdata), .rd_req(rd_req),
        .rd_data(rd_data), .busy(busy), .done(done), .final_pass(final_pass),
        .err_code(err_code), .fail_addr(fail_addr), .fail_cnt(fail_cnt));

    logic [DW-1:0] src_mem [64];
    logic [DW-1:0] cell_mem [64];
    logic [DW-1:0] init_mem [64];
    int need_mem [64], cnt_mem [64], obs_p [64], exp_p [64];
    int n_chk = 0, n_fail = 0, cyc = 0;
    int obs_final = 0, dist_a = -1, dist_t = -1, run_first = 0;
    int exp_err, exp_faddr, exp_fcnt, exp_stop;

    assign src_data = src_mem[cell_addr];
    assign rd_data  = cell_mem[cell_addr];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // cell model and timing monitor, sampled away from the active edge
    logic p_prev = 1, r_prev = 0;
    logic [AW-1:0] a_prev = '0;
    logic [DW-1:0] w_prev = '0;
    int lowc = 0, stab = 0, gapc = 0, rdc = 0;
    bit gap_on = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy && cell_addr != a_prev)
                chk(cell_addr == a_prev + 1 || int'(cell_addr) == run_first,
                    "R2 address order", cell_addr, a_prev + 1);
            if (!prog_n) begin
                if (p_prev) chk(stab >= SU, "R3 setup stability", stab, SU);
                lowc++;
            end else if (!p_prev) begin
                chk(lowc == PW, "R3 pulse width", lowc, PW);
                lowc = 0;
                obs_p[cell_addr]++;
                if (final_pass) obs_final++;
                cnt_mem[cell_addr]++;
                if (cnt_mem[cell_addr] == need_mem[cell_addr])
                    cell_mem[cell_addr] = cell_mem[cell_addr] & cell_wdata;
                if (int'(cell_addr) == dist_t && dist_a >= 0)
                    cell_mem[dist_a] = cell_mem[dist_a] & 16'hFFFE;
                gap_on = 1; gapc = 0;
            end
            if (gap_on) begin
                if (rd_req) begin
                    chk(gapc == HO, "R3 hold gap", gapc, HO);
                    gap_on = 0;
                end else gapc++;
            end
            if (rd_req) rdc++;
            else if (r_prev) begin
                chk(rdc == RL, "R4 read length", rdc, RL);
                rdc = 0;
            end
            stab = (cell_addr == a_prev && cell_wdata == w_prev) ? stab + 1 : 0;
        end
        p_prev = prog_n; r_prev = rd_req; a_prev = cell_addr; w_prev = cell_wdata;
    end

    task automatic summary_and_end();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(negedge clk) if (cyc > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        summary_and_end();
    end

    task automatic predict(input int f, input int l);
        exp_err = 0; exp_faddr = 0; exp_fcnt = 0; exp_stop = l;
        for (int a = f; a <= l; a++) begin
            exp_p[a] = 0;
            if ((src_mem[a] & ~init_mem[a]) != 0) begin
                exp_err = 1; exp_faddr = a; exp_stop = a; return;
            end
            if (init_mem[a] != src_mem[a]) begin
                if (need_mem[a] == 0 || need_mem[a] > MP) begin
                    exp_p[a] = MP; exp_err = 2; exp_faddr = a; exp_fcnt = MP;
                    exp_stop = a; return;
                end
                exp_p[a] = need_mem[a];
            end
        end
        if (dist_a >= f && dist_a <= l) begin
            exp_err = 3; exp_faddr = dist_a;
        end
    endtask

    task automatic fill(input int f, input int l);
        for (int a = f; a <= l; a++) begin
            src_mem[a]  = 16'($urandom);
            cell_mem[a] = 16'hFFFF;
            need_mem[a] = 1 + int'($urandom % 20);
        end
    endtask

    task automatic run_case(input int f, input int l, input bit mid_start);
        for (int a = 0; a < 64; a++) begin
            init_mem[a] = cell_mem[a]; cnt_mem[a] = 0; obs_p[a] = 0;
        end
        obs_final = 0;
        predict(f, l);
        first_addr = AW'(f); last_addr = AW'(l); run_first = f;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        if (mid_start) begin
            repeat (40) @(negedge clk);
            first_addr = '0; last_addr = '1; start = 1;
            @(negedge clk); start = 0;
        end
        while (!done) @(negedge clk);
        chk(done == 1, "R10 done", done, 1);
        chk(int'(err_code) == exp_err, "R6/R8/R9 err_code", err_code, exp_err);
        if (exp_err != 0) begin
            chk(int'(fail_addr) == exp_faddr, "R6/R8/R9 fail_addr", fail_addr, exp_faddr);
            chk(int'(fail_cnt) == exp_fcnt, "R6/R8/R9 fail_cnt", fail_cnt, exp_fcnt);
        end
        for (int a = f; a <= exp_stop; a++) begin
            chk(obs_p[a] == exp_p[a], "R7/R5 pulses per word", obs_p[a], exp_p[a]);
            if (exp_err == 0)
                chk(cell_mem[a] == src_mem[a], "R2 word content", cell_mem[a], src_mem[a]);
        end
        chk(obs_final == 0, "R9 no pulse in final pass", obs_final, 0);
        repeat (5) @(negedge clk);
        chk(done == 1 && busy == 0, "R10 done held", done, 1);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int a = 0; a < 64; a++) begin
            src_mem[a] = 16'hFFFF; cell_mem[a] = 16'hFFFF; need_mem[a] = 1;
        end
        repeat (3) @(negedge clk);
        chk(prog_n == 1 && rd_req == 0, "R1 reset pins", {prog_n, rd_req}, 2);
        chk(busy == 0 && done == 0 && err_code == 0, "R1 reset status", {busy, done, err_code}, 0);
        rst_n = 1;
        @(negedge clk);
        // R2 R7 random window, with an ignored start mid-run (R10)
        fill(0, 11);
        run_case(0, 11, 1);
        // R8 a word that never programs
        fill(20, 27);
        src_mem[24] = 16'h1234; need_mem[24] = 0;
        run_case(20, 27, 0);
        // R6 target needs a 1 where the cell already holds 0
        fill(30, 35);
        cell_mem[33] = 16'h00F0; src_mem[33] = 16'h0F00;
        run_case(30, 35, 0);
        // R7 exact budget, R5 pre-programmed word
        fill(40, 44);
        src_mem[40] = 16'hA5A5; need_mem[40] = MP;
        src_mem[42] = 16'h3C3C; cell_mem[42] = 16'h3C3C;
        run_case(40, 44, 0);
        // single-word window
        fill(46, 46);
        run_case(46, 46, 0);
        // R9 an earlier word disturbed after it passed
        fill(50, 55);
        src_mem[51] = 16'h0F0F; src_mem[53] = 16'h0000; need_mem[53] = 3;
        dist_a = 51; dist_t = 53;
        run_case(50, 55, 0);
        dist_a = -1; dist_t = -1;
        summary_and_end();
    end
endmodule